// File: doc/BRIEF.md
# Full-to-Half-Rate Read Capture

This block sits in the read path of a double-data-rate, source-synchronous SRAM interface and serves one data group, which means one memory device. Read beats arrive on a bus of `DATA_W` bits. One beat is captured on each rising edge of the echo clock and one on each rising edge of its complement, so the block takes two beats per echo period. It divides the echo clock by two to make a half-rate clock, `clk_half`. On each rising edge of that clock it presents four consecutive beats as one word of `4*DATA_W` bits, on a write-side interface meant for a clock-crossing FIFO.

The polarity of the divided clock can be selected with `inv_sel`. Changing the polarity moves word assembly by one echo period, which swaps which beat pair lands in the upper half of the word and which lands in the lower half. A calibration controller outside the block picks the polarity that gives the correct byte order. A new polarity request passes through a short settle window before it takes effect. The write strobe stays low during that window and during a warm-up after reset.

Top module: `rdcap_full_to_half`

## Requirements
- R1: Both beats of every echo period reach the output word: one is sampled at the rising edge of `clk_echo`, the other at the rising edge of `clk_echo_n`.
- R2: A word loaded at echo edge e is laid out from bit 0 upward in four DATA_W slices: the rise beat sampled at edge e-2, the fall beat that followed it, the rise beat sampled at edge e-1, and the fall beat that followed that one.
- R3: `clk_half` is registered on `clk_echo` and inverts at every echo edge out of reset. The only exception is the edge that applies a new polarity, where it holds its value.
- R4: `wr_data` is loaded only at echo edges where `clk_half` goes from 0 to 1, so the word changes together with the rising edge of `clk_half`.
- R5: Reset is synchronous and active low. While `rst_n` is low, `clk_half` and the applied polarity follow `inv_sel`, `wr_valid` is 0 and `wr_data` is 0.
- R6: After reset, the first two loads are warm-up loads and leave `wr_valid` at 0. `wr_valid` is 1 from the third load onward, and it holds its value between loads.
- R7: A polarity change is detected at an echo edge where `inv_sel` differs from the applied polarity and no settle is pending. `wr_valid` drops at that edge. The new polarity is applied SETTLE_CYC edges later (2 by default).
- R8: Changes of `inv_sel` during a settle window are ignored. When the window ends, `inv_sel` is compared again with the applied polarity, and a difference starts a new window.
- R9: Once a settle window ends, `wr_valid` returns to 1 at the next load, with no new warm-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_echo | input | 1 | Echo clock from the memory; the full-rate clock |
| clk_echo_n | input | 1 | Complement of the echo clock |
| rst_n | input | 1 | Synchronous active-low reset, in the `clk_echo` domain |
| inv_sel | input | 1 | Requested polarity of the divided clock, synchronous to `clk_echo` |
| din | input | DATA_W | Read data beats |
| clk_half | output | 1 | Divided half-rate clock, used as the FIFO write clock |
| wr_data | output | 4*DATA_W | Assembled half-rate word, oldest beat in the low slice |
| wr_valid | output | 1 | Write strobe, sampled at the rising edge of `clk_half` |

## Verification
The words, `clk_half` and `wr_valid` are all registered on the echo clock. Each is due at the first echo edge whose sampled inputs hold the stimulus, and a polarity request adds SETTLE_CYC further edges before `clk_half` holds. The bench's reference model updates at every echo edge from the inputs sampled there. The outputs are compared 2 ns after that edge, before the complement edge, so each comparison sees exactly the result that edge is due to produce. Beats are driven as a running count, which lets word order and beat grouping be checked both against the model and directly, as consecutive slice values.

// File: rtl/rdcap_pkg.sv
// Package rdcap_pkg
// Shared constants and a width helper for the read capture block.
// Assumes nothing beyond elaboration-time integer arithmetic.
package rdcap_pkg;
    localparam int BEATS_PER_WORD = 4;

    // Number of bits needed to count from 0 up to n inclusive
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/rdcap_beat_capture.sv
// Module rdcap_beat_capture
// Samples one beat on each rising edge of the echo clock and one on each rising
// edge of its complement, then keeps the previous beat pair. The pairs are kept
// in the echo domain.
// Assumes clk_echo_n is the complement of clk_echo and din is stable at both edges.
module rdcap_beat_capture #(
    parameter int DATA_W = 8
) (
    input  logic                clk_echo,
    input  logic                clk_echo_n,
    input  logic [DATA_W-1:0]   din,
    output logic [2*DATA_W-1:0] pair_new,
    output logic [2*DATA_W-1:0] pair_old
);
    logic [DATA_W-1:0] rise_q;
    logic [DATA_W-1:0] fall_q;

    // Rise beat: sampled at the echo clock edge
    always_ff @(posedge clk_echo) begin
        rise_q <= din;
    end

    // Fall beat: sampled at the complement clock edge
    always_ff @(posedge clk_echo_n) begin
        fall_q <= din;
    end

    // Most recent complete pair, rise beat in the low half
    assign pair_new = {fall_q, rise_q};

    // Pair from one echo period earlier
    always_ff @(posedge clk_echo) begin
        pair_old <= pair_new;
    end
endmodule

// File: rtl/rdcap_phase_ctl.sv
// Module rdcap_phase_ctl
// Makes the divided clock and the word-load enable. It also runs the polarity
// settle window and the post-reset warm-up, and drives the write strobe.
// Assumes inv_sel is synchronous to clk. Reset is synchronous and active low.
module rdcap_phase_ctl #(
    parameter int SETTLE_CYC = 2,
    parameter int WARM_LOADS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inv_sel,
    output logic half_q,
    output logic load,
    output logic valid
);
    import rdcap_pkg::*;

    localparam int SC_W   = cnt_w(SETTLE_CYC);
    localparam int WARM_W = cnt_w(WARM_LOADS);

    logic              inv_eff;
    logic              inv_tgt;
    logic [SC_W-1:0]   sc;
    logic [SC_W-1:0]   sc_nxt;
    logic [WARM_W-1:0] warm;
    logic              detect;
    logic              flip;

    // Settle window: start on a mismatch, then count down to the apply edge
    always_comb begin
        flip   = (sc == SC_W'(1));
        detect = (sc == '0) && (inv_sel != inv_eff);
        if (sc == '0) begin
            sc_nxt = detect ? SC_W'(SETTLE_CYC) : '0;
        end else begin
            sc_nxt = sc - SC_W'(1);
        end
    end

    // Load when the divided clock is about to rise and is not being held
    assign load = !flip && !half_q;

    // State update for polarity, divided clock, warm-up and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q  <= inv_sel;
            inv_eff <= inv_sel;
            inv_tgt <= inv_sel;
            sc      <= '0;
            warm    <= '0;
            valid   <= 1'b0;
        end else begin
            sc <= sc_nxt;
            if (detect) begin
                inv_tgt <= inv_sel;
            end
            if (flip) begin
                inv_eff <= inv_tgt;
            end
            half_q <= flip ? half_q : ~half_q;
            if (load && (warm != WARM_W'(WARM_LOADS))) begin
                warm <= warm + WARM_W'(1);
            end
            if (sc_nxt != '0) begin
                valid <= 1'b0;
            end else if (load) begin
                valid <= (warm == WARM_W'(WARM_LOADS));
            end
        end
    end

    // R3: the divided clock holds on the apply edge
    p_half_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sc == SC_W'(1)) |=> $stable(half_q));

    // R3: the divided clock inverts at every other edge
    p_half_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sc != SC_W'(1)) |=> (half_q != $past(half_q)));

    // R7: no write strobe while a settle window is open
    p_quiet_settle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sc != '0) |-> !valid);

    // R7: the applied polarity only moves at the end of a settle window
    p_apply_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(inv_eff)) |-> ($past(sc) == SC_W'(1)));

    // R6: the strobe is only high once warm-up is complete
    p_warm_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (warm == WARM_W'(WARM_LOADS)));
endmodule

// File: rtl/rdcap_word_asm.sv
// Module rdcap_word_asm
// Puts two beat pairs together into one half-rate word on each load enable. The
// older pair goes in the low half.
// Assumes load is high only on the edge where the divided clock rises.
module rdcap_word_asm #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                clk_half_i,
    input  logic [2*DATA_W-1:0] pair_new,
    input  logic [2*DATA_W-1:0] pair_old,
    output logic [4*DATA_W-1:0] word
);
    // Word register: captured on the load edge, cleared in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (load) begin
            word <= {pair_new, pair_old};
        end
    end

    // R4: the word only changes together with a rising divided clock
    p_load_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (word != $past(word))) |-> $rose(clk_half_i));
endmodule

// File: rtl/rdcap_full_to_half.sv
// Module rdcap_full_to_half
// Read capture for one data group. Double-rate beats become half-rate words of
// four beats, driven on a FIFO write-side interface clocked by the divided clock.
// Assumes one instance per memory device. inv_sel and rst_n are synchronous to
// clk_echo.
module rdcap_full_to_half #(
    parameter int DATA_W     = 8,
    parameter int SETTLE_CYC = 2,
    parameter int WARM_LOADS = 2
) (
    input  logic                                    clk_echo,
    input  logic                                    clk_echo_n,
    input  logic                                    rst_n,
    input  logic                                    inv_sel,
    input  logic [DATA_W-1:0]                       din,
    output logic                                    clk_half,
    output logic [rdcap_pkg::BEATS_PER_WORD*DATA_W-1:0] wr_data,
    output logic                                    wr_valid
);
    localparam int PAIR_W = 2 * DATA_W;

    logic [PAIR_W-1:0] pair_new;
    logic [PAIR_W-1:0] pair_old;
    logic              load;

    rdcap_beat_capture #(.DATA_W(DATA_W)) u_cap (
        .clk_echo   (clk_echo),
        .clk_echo_n (clk_echo_n),
        .din        (din),
        .pair_new   (pair_new),
        .pair_old   (pair_old)
    );

    rdcap_phase_ctl #(.SETTLE_CYC(SETTLE_CYC), .WARM_LOADS(WARM_LOADS)) u_ctl (
        .clk     (clk_echo),
        .rst_n   (rst_n),
        .inv_sel (inv_sel),
        .half_q  (clk_half),
        .load    (load),
        .valid   (wr_valid)
    );

    rdcap_word_asm #(.DATA_W(DATA_W)) u_asm (
        .clk        (clk_echo),
        .rst_n      (rst_n),
        .load       (load),
        .clk_half_i (clk_half),
        .pair_new   (pair_new),
        .pair_old   (pair_old),
        .word       (wr_data)
    );
endmodule

// File: tb/rdcap_full_to_half_tb.sv
`timescale 1ns/1ps
module rdcap_full_to_half_tb;
    localparam int DW     = 8;
    localparam int SETTLE = 2;
    localparam int WARM   = 2;

    logic          clk_echo = 1'b0;
    logic          clk_echo_n;
    logic          rst_n = 1'b0;
    logic          inv_sel = 1'b0;
    logic [DW-1:0] din = '0;
    logic          clk_half;
    logic [4*DW-1:0] wr_data;
    logic          wr_valid;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    assign clk_echo_n = ~clk_echo;

    rdcap_full_to_half #(.DATA_W(DW), .SETTLE_CYC(SETTLE), .WARM_LOADS(WARM)) u_dut (
        .clk_echo   (clk_echo),
        .clk_echo_n (clk_echo_n),
        .rst_n      (rst_n),
        .inv_sel    (inv_sel),
        .din        (din),
        .clk_half   (clk_half),
        .wr_data    (wr_data),
        .wr_valid   (wr_valid)
    );

    // 200 MHz echo clock
    always #2.5 clk_echo = ~clk_echo;

    // Beats: a running count, changed mid-way between sampling edges
    logic [DW-1:0] beat = 8'h10;
    always @(clk_echo) begin
        #1.25;
        din  = beat;
        beat = beat + 1'b1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state
    bit            m_half, m_inv, m_tgt, m_valid;
    int            m_sc, m_warm;
    logic [4*DW-1:0] m_data;
    logic [DW-1:0] m_lr, m_lf, m_pr, m_pf;
    bit            m_rst;

    // Fall beat of the model
    always @(posedge clk_echo_n) m_lf = din;

    // Model update at each echo edge, then compare before the complement edge
    always @(posedge clk_echo) begin
        bit flip, ld, det;
        int nsc;
        logic [4*DW-1:0] cand;
        cand = {m_lf, m_lr, m_pf, m_pr};
        m_pr = m_lr;
        m_pf = m_lf;
        m_lr = din;
        m_rst = !rst_n;
        if (!rst_n) begin
            m_half = inv_sel; m_inv = inv_sel; m_tgt = inv_sel;
            m_sc = 0; m_warm = 0; m_valid = 0; m_data = '0;
        end else begin
            flip = (m_sc == 1);
            det  = (m_sc == 0) && (inv_sel != m_inv);
            if (det) begin nsc = SETTLE; m_tgt = inv_sel; end
            else if (m_sc == 0) nsc = 0;
            else nsc = m_sc - 1;
            if (flip) m_inv = m_tgt;
            ld = !flip && !m_half;
            if (ld) m_data = cand;
            if (nsc != 0) m_valid = 0;
            else if (ld) m_valid = (m_warm == WARM);
            if (ld && m_warm < WARM) m_warm++;
            m_half = flip ? m_half : !m_half;
            m_sc = nsc;
        end
        #2;
        if (!done) begin
            if (m_rst) begin
                chk("R5 clk_half in reset", 64'(clk_half), 64'(m_half));
                chk("R5 wr_valid in reset", 64'(wr_valid), 64'(0));
                chk("R5 wr_data in reset", 64'(wr_data), 64'(0));
            end else begin
                chk("R3 clk_half", 64'(clk_half), 64'(m_half));
                chk("R6 R7 R8 R9 wr_valid", 64'(wr_valid), 64'(m_valid));
                if (m_valid) begin
                    chk("R1 R2 R4 wr_data", 64'(wr_data), 64'(m_data));
                    // R2: slices hold consecutive beats, oldest lowest
                    chk("R2 slice1", 64'(wr_data[2*DW-1:DW]), 64'(DW'(wr_data[DW-1:0] + 1'b1)));
                    chk("R2 slice3", 64'(wr_data[4*DW-1:3*DW]), 64'(DW'(wr_data[DW-1:0] + 2'd3)));
                end
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk_echo);
    endtask

    initial begin
        run(4);
        rst_n = 1'b1;
        run(30);
        inv_sel = 1'b1;          // R7: polarity change, grouping shifts
        run(20);
        inv_sel = 1'b0;          // R7 back
        run(20);
        inv_sel = 1'b1;          // R8: pulse shorter than the settle window
        run(1);
        inv_sel = 1'b0;
        run(20);
        inv_sel = 1'b1;          // R5: reset with the other polarity
        rst_n = 1'b0;
        run(3);
        rst_n = 1'b1;
        run(25);
        inv_sel = 1'b0;          // R9: resume without warm-up
        run(3);
        inv_sel = 1'b1;
        run(25);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk_echo);
        done = 1;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule